// File: doc/BRIEF.md
# Error Interrupt Status Controller

This block gathers three error event lines (protection violation, address violation and lock violation) into a single level interrupt. Each line sets a sticky raw status bit. Software sees those bits before masking through a raw register, and after masking through a pending register. Enables are held in one register that has two write ports: one write-1-to-set view and one write-1-to-clear view. Software can set raw bits itself to inject test events. It retires serviced events by writing ones to the pending register.

An 8-bit end-of-interrupt vector register completes the service handshake. Each write to it emits a one-cycle pulse toward a downstream interrupt distributor, together with the vector value. The register bus is a simple single-cycle slave: writes take effect at the clock edge on which `bus_sel` and `bus_wr` are both high. Read data is combinational while `bus_sel` is high and `bus_wr` is low. The two low address bits are ignored. Byte offsets are 0x00 raw, 0x04 pending, 0x08 enable-set, 0x0C enable-clear and 0x10 end-of-interrupt.

Top module: `err_irq_ctrl`

## Requirements
- R1: After reset, the raw, pending and enable registers and the vector all read 0, and `irq_o` and `eoi_pulse_o` are low.
- R2: A high level on `evt_i[k]` at a clock edge sets raw bit k. Bit 0 is protection, bit 1 is address and bit 2 is lock.
- R3: Writing 1 to a bit of the raw register (offset 0x00) sets that bit. Writing 0 to a bit leaves it unchanged.
- R4: The pending register (offset 0x04) reads raw AND enable. Writing 1 to a bit of it clears that raw bit. Writing 0 to a bit leaves it unchanged.
- R5: Writing 1 to a bit at offset 0x08 sets that enable bit, and writing 1 to a bit at offset 0x0C clears it. Zeros have no effect. Both offsets read back the current enables.
- R6: `irq_o` is high exactly when at least one bit is set in both raw status and enable.
- R7: When a hardware event and a pending-register clear reach the same bit at the same edge, the bit stays set.
- R8: Bit 3 is reserved. Bits 31..3 of the raw, pending and enable registers always read 0, and writing to them has no effect.
- R9: Offset 0x10 holds an 8-bit read/write vector in bits 7..0. Bits 31..8 read 0.
- R10: A write to offset 0x10 makes `eoi_pulse_o` high for exactly the one cycle after the write edge, with `eoi_vec_o` equal to the written bits 7..0.
- R11: Reads from any other offset return 0, and writes to any other offset change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 3 | Hardware error events, one per source |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Combined interrupt |
| eoi_pulse_o | output | 1 | One-cycle end-of-interrupt strobe |
| eoi_vec_o | output | 8 | Last written end-of-interrupt vector |

## Verification
A hardware event and a software clear of the same raw bit can land on the same clock edge. The bench provokes this by driving the event line during a ones-write to the pending register. The bit must still be set afterwards, and `irq_o` must stay high. A later clear with no event present must then retire the bit, which shows that the first clear was overridden rather than ignored.

// File: rtl/eic_pkg.sv
// Shared types for the error interrupt status controller.
// Assumes a fixed map of five word registers starting at offset zero.
package eic_pkg;

    localparam int REG_COUNT = 5;

    // Register selected by the current bus address.
    typedef enum logic [2:0] {
        RS_RAW   = 3'd0,
        RS_PEND  = 3'd1,
        RS_ENSET = 3'd2,
        RS_ENCLR = 3'd3,
        RS_EOI   = 3'd4,
        RS_NONE  = 3'd7
    } reg_sel_e;

    // One write strobe per writable register.
    typedef struct packed {
        logic raw_set;
        logic pend_clr;
        logic en_set;
        logic en_clr;
        logic eoi;
    } wr_strobe_t;

endpackage

// File: rtl/eic_decode.sv
// Address decoder: turns a bus access into a register select and write strobes.
// Assumes word-aligned registers; the two low address bits are ignored.
module eic_decode
    import eic_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_sel_e          rd_sel,
    output wr_strobe_t        wr_strb
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word_idx;
    reg_sel_e         hit_sel;

    assign word_idx = bus_addr[ADDR_W-1:2];

    // Map the word index onto a register, or to none.
    always_comb begin
        case (word_idx)
            IDX_W'(0): hit_sel = RS_RAW;
            IDX_W'(1): hit_sel = RS_PEND;
            IDX_W'(2): hit_sel = RS_ENSET;
            IDX_W'(3): hit_sel = RS_ENCLR;
            IDX_W'(4): hit_sel = RS_EOI;
            default:   hit_sel = RS_NONE;
        endcase
    end

    // Qualify the select with the access kind.
    always_comb begin
        rd_sel  = RS_NONE;
        wr_strb = '0;
        if (bus_sel && !bus_wr) begin
            rd_sel = hit_sel;
        end
        if (bus_sel && bus_wr) begin
            wr_strb.raw_set  = (hit_sel == RS_RAW);
            wr_strb.pend_clr = (hit_sel == RS_PEND);
            wr_strb.en_set   = (hit_sel == RS_ENSET);
            wr_strb.en_clr   = (hit_sel == RS_ENCLR);
            wr_strb.eoi      = (hit_sel == RS_EOI);
        end
    end

endmodule

// File: rtl/eic_status.sv
// Per-source raw status and enable bits.
// Raw bits are set by hardware events or by software, and cleared by software.
// A hardware event overrides a clear at the same edge.
module eic_status #(
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic [NUM_SRC-1:0] wbits,
    input  logic               raw_set,
    input  logic               pend_clr,
    input  logic               en_set,
    input  logic               en_clr,
    output logic [NUM_SRC-1:0] raw_q,
    output logic [NUM_SRC-1:0] en_q
);

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        logic set_k;
        logic clr_k;

        assign set_k = evt_i[k] | (raw_set & wbits[k]);
        assign clr_k = pend_clr & wbits[k];

        // Sticky raw bit; the set path has priority over the clear path.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                raw_q[k] <= 1'b0;
            end else if (set_k) begin
                raw_q[k] <= 1'b1;
            end else if (clr_k) begin
                raw_q[k] <= 1'b0;
            end
        end

        // Enable bit with separate set and clear ports.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[k] <= 1'b0;
            end else if (en_set && wbits[k]) begin
                en_q[k] <= 1'b1;
            end else if (en_clr && wbits[k]) begin
                en_q[k] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/eic_eoi.sv
// End-of-interrupt vector register with a one-cycle service strobe.
// Assumes the consumer samples the vector while the strobe is high.
module eic_eoi #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_eoi,
    input  logic [VEC_W-1:0] wvec,
    output logic [VEC_W-1:0] vec_q,
    output logic             pulse_q
);

    // Hold the last vector written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (wr_eoi) begin
            vec_q <= wvec;
        end
    end

    // Strobe for one cycle after each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= wr_eoi;
        end
    end

endmodule

// File: rtl/err_irq_ctrl.sv
// Top of the error interrupt status controller.
// Collects event lines into one interrupt and serves the register bus.
// Assumes a single-cycle bus with combinational read data.
module err_irq_ctrl
    import eic_pkg::*;
#(
    parameter int NUM_SRC = 3,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int VEC_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              eoi_pulse_o,
    output logic [VEC_W-1:0]  eoi_vec_o
);

    reg_sel_e           rd_sel;
    wr_strobe_t         wr_strb;
    logic [NUM_SRC-1:0] raw_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] pend;
    logic [VEC_W-1:0]   vec_q;
    logic               unused_bits;

    assign unused_bits = ^{bus_wdata[DATA_W-1:NUM_SRC], bus_addr[1:0]};

    eic_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .rd_sel   (rd_sel),
        .wr_strb  (wr_strb)
    );

    eic_status #(.NUM_SRC(NUM_SRC)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .wbits    (bus_wdata[NUM_SRC-1:0]),
        .raw_set  (wr_strb.raw_set),
        .pend_clr (wr_strb.pend_clr),
        .en_set   (wr_strb.en_set),
        .en_clr   (wr_strb.en_clr),
        .raw_q    (raw_q),
        .en_q     (en_q)
    );

    eic_eoi #(.VEC_W(VEC_W)) u_eoi (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_eoi  (wr_strb.eoi),
        .wvec    (bus_wdata[VEC_W-1:0]),
        .vec_q   (vec_q),
        .pulse_q (eoi_pulse_o)
    );

    assign pend      = raw_q & en_q;
    assign irq_o     = |pend;
    assign eoi_vec_o = vec_q;

    // Read multiplexer; unselected or unmapped reads return zero.
    always_comb begin
        case (rd_sel)
            RS_RAW:   bus_rdata = DATA_W'(raw_q);
            RS_PEND:  bus_rdata = DATA_W'(pend);
            RS_ENSET: bus_rdata = DATA_W'(en_q);
            RS_ENCLR: bus_rdata = DATA_W'(en_q);
            RS_EOI:   bus_rdata = DATA_W'(vec_q);
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/eic_chk.sv
// Property checker for err_irq_ctrl, attached by bind.
module eic_chk #(
    parameter int NUM_SRC = 3,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int VEC_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] evt_i,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               irq_o,
    input logic               eoi_pulse_o,
    input logic [VEC_W-1:0]   eoi_vec_o,
    input logic [NUM_SRC-1:0] raw_q,
    input logic [NUM_SRC-1:0] en_q
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    assign idx = bus_addr[ADDR_W-1:2];

    // R2 R7
    event_sets_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((raw_q & $past(evt_i)) == $past(evt_i)));

    // R4
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && idx == IDX_W'(1))
        |=> ((raw_q & $past(bus_wdata[NUM_SRC-1:0] & ~evt_i)) == '0));

    // R5
    enable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && idx == IDX_W'(2))
        |=> ((en_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0])));

    // R6
    no_enable_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq_o);

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && idx < IDX_W'(4)) |-> (bus_rdata[DATA_W-1:NUM_SRC] == '0));

    // R10
    eoi_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && idx == IDX_W'(4))
        |=> (eoi_pulse_o && eoi_vec_o == $past(bus_wdata[VEC_W-1:0])));

endmodule

bind err_irq_ctrl eic_chk #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .irq_o       (irq_o),
    .eoi_pulse_o (eoi_pulse_o),
    .eoi_vec_o   (eoi_vec_o),
    .raw_q       (raw_q),
    .en_q        (en_q)
);

// File: tb/err_irq_ctrl_test.sv
`timescale 1ns/1ps
module err_irq_ctrl_test;

    localparam logic [7:0] A_RAW = 8'h00;
    localparam logic [7:0] A_PND = 8'h04;
    localparam logic [7:0] A_ENS = 8'h08;
    localparam logic [7:0] A_ENC = 8'h0C;
    localparam logic [7:0] A_EOI = 8'h10;
    localparam logic [7:0] A_BAD = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  evt_i = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;
    logic        eoi_pulse_o;
    logic [7:0]  eoi_vec_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    err_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .eoi_pulse_o(eoi_pulse_o), .eoi_vec_o(eoi_vec_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Write at one edge, optionally with events at the same edge.
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [2:0] ev);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; evt_i = ev;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; evt_i = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(req, d, exp);
    endtask

    task automatic t_reset;
        expect_reg("R1 raw", A_RAW, 0);
        expect_reg("R1 pend", A_PND, 0);
        expect_reg("R1 enable", A_ENS, 0);
        expect_reg("R1 vector", A_EOI, 0);
        check("R1 irq", {31'd0, irq_o}, 0);
        check("R1 eoi pulse", {31'd0, eoi_pulse_o}, 0);
    endtask

    task automatic t_hw_event;
        @(negedge clk); evt_i = 3'b010;
        @(posedge clk);
        @(negedge clk); evt_i = '0;
        expect_reg("R2 address event", A_RAW, 32'h2);
        expect_reg("R4 pend masked", A_PND, 0);
        check("R6 irq masked", {31'd0, irq_o}, 0);
    endtask

    task automatic t_sw_set;
        bus_write(A_RAW, 32'h5, 3'b0);
        expect_reg("R3 raw set", A_RAW, 32'h7);
        bus_write(A_RAW, 32'h0, 3'b0);
        expect_reg("R3 zero write", A_RAW, 32'h7);
        bus_write(A_RAW, 32'hFFFF_FFF8, 3'b0);
        expect_reg("R8 raw upper", A_RAW, 32'h7);
    endtask

    task automatic t_enable;
        bus_write(A_ENS, 32'h1, 3'b0);
        expect_reg("R5 set readback", A_ENS, 32'h1);
        expect_reg("R5 clr readback", A_ENC, 32'h1);
        expect_reg("R4 pend", A_PND, 32'h1);
        check("R6 irq on", {31'd0, irq_o}, 1);
        bus_write(A_ENS, 32'hFFFF_FFF8, 3'b0);
        expect_reg("R8 enable upper", A_ENS, 32'h1);
        bus_write(A_ENC, 32'h1, 3'b0);
        expect_reg("R5 cleared", A_ENS, 32'h0);
        check("R6 irq off", {31'd0, irq_o}, 0);
        bus_write(A_ENS, 32'h6, 3'b0);
        bus_write(A_ENC, 32'h0, 3'b0);
        expect_reg("R5 zero clear", A_ENC, 32'h6);
        expect_reg("R4 pend two", A_PND, 32'h6);
    endtask

    task automatic t_clear;
        bus_write(A_PND, 32'h2, 3'b0);
        expect_reg("R4 clear raw", A_RAW, 32'h5);
        expect_reg("R4 pend after", A_PND, 32'h4);
        bus_write(A_PND, 32'h0, 3'b0);
        expect_reg("R4 zero write", A_RAW, 32'h5);
        bus_write(A_PND, 32'h4, 3'b0);
        expect_reg("R4 clear lock", A_RAW, 32'h1);
        check("R6 irq after clear", {31'd0, irq_o}, 0);
    endtask

    task automatic t_race;
        bus_write(A_ENS, 32'h1, 3'b0);
        bus_write(A_PND, 32'h1, 3'b001);
        expect_reg("R7 event wins", A_RAW, 32'h1);
        check("R7 irq held", {31'd0, irq_o}, 1);
        bus_write(A_PND, 32'h1, 3'b0);
        expect_reg("R7 later clear", A_RAW, 32'h0);
        check("R6 irq idle", {31'd0, irq_o}, 0);
    endtask

    task automatic t_eoi;
        bus_write(A_EOI, 32'h1A5, 3'b0);
        check("R10 pulse high", {31'd0, eoi_pulse_o}, 1);
        check("R10 vector out", {24'd0, eoi_vec_o}, 32'hA5);
        expect_reg("R9 readback", A_EOI, 32'hA5);
        @(negedge clk);
        check("R10 pulse single", {31'd0, eoi_pulse_o}, 0);
    endtask

    task automatic t_unmapped;
        bus_write(A_BAD, 32'hFF, 3'b0);
        bus_write(8'h3C, 32'hFF, 3'b0);
        expect_reg("R11 read zero", A_BAD, 0);
        expect_reg("R11 raw kept", A_RAW, 0);
        expect_reg("R11 enable kept", A_ENS, 32'h7);
        expect_reg("R11 vector kept", A_EOI, 32'hA5);
        check("R11 no pulse", {31'd0, eoi_pulse_o}, 0);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_hw_event();
        t_sw_set();
        t_enable();
        t_clear();
        t_race();
        t_eoi();
        t_unmapped();
        finish_run();
    end

endmodule